// File: doc/BRIEF.md
# Interface Clock Frequency Meter

This block measures how fast an interface clock runs compared with a reference clock, which is usually the processor clock. It opens a gate window of a fixed number of reference cycles and counts the rising edges of the measured clock inside that window. The count then crosses into the reference domain as a held snapshot with a toggle handshake. It is published as a 32-bit unsigned fixed-point ratio with 16 integer and 16 fraction bits. A value of `0x0001_0000` means the two clocks run at the same rate.

The window length is `2**GATE_LOG2` reference cycles. With the default of 16 the edge count is the 16.16 ratio itself. With a shorter window the count is shifted left so that the binary point stays fixed. At a 100 MHz reference, the smallest nonzero step at the default window is about 1.5 kHz and the largest ratio is just under 65536. The published value is zero after reset. It changes only when a window completes and holds between completions. A measured clock fast enough to overflow the edge counter produces the largest count rather than a wrapped one.

The result is valid while one measured period is shorter than the window divided by about `SYNC_STAGES + 2`. This is the time the handshake needs to complete.

Top module: `clk_freq_meter`

## Requirements
- R1: `freq_q` equals N × 2^(16−GATE_LOG2), where N is the number of measured-clock rising edges in one window. The low (16−GATE_LOG2) bits are therefore always zero, and equal clocks read `0x0001_0000`.
- R2: A window lasts exactly 2^GATE_LOG2 reference cycles. A new snapshot request is issued only at a window boundary.
- R3: While `ref_rst` is high, and after its release until the first completed window has been transferred, `freq_q` reads 0.
- R4: `freq_q` changes only in the cycle after a completed transfer. It changes at most once per window and holds its value in between.
- R5: When the edge count reaches 2^CNT_W−1 inside a window, it stays there and does not wrap. `freq_q` then shows the largest count.
- R6: The snapshot is held constant in the measured domain except at a capture. The reference domain loads it only after the acknowledge returns, so a steady measured clock never yields a torn or stray value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; window timing and result register |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain (also forwarded into the measured domain) |
| meas_clk | input | 1 | Clock whose frequency is measured |
| freq_q | output | 32 | Measured frequency as unsigned 16.16 ratio to `ref_clk` |

## Verification
The bench runs a small configuration: a 64-cycle window and a 9-bit counter. It sweeps the measured clock across integer and fractional ratios, from one edge up to well past the counter limit. It compares each result with the arithmetic count of edges in the window, shifted by ten bits.

Several faults are each caught by a distinct symptom:
- A window off by one cycle moves the equal-clock reading away from `0x0001_0000`.
- A counter that wraps instead of saturating reads a small value at the 1 ns period.
- A result register that is not cleared shows a stale nonzero value after a reset in mid-operation.
- A transfer that loads without waiting for the acknowledge shows values that jump between samples within one window.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

    // Output format: 16 integer bits, 16 fraction bits.
    localparam int RES_W  = 32;
    localparam int FRAC_W = 16;

    // Reference-side handshake state.
    typedef enum logic {
        GT_ARMED   = 1'b0,
        GT_PENDING = 1'b1
    } gate_state_e;

    // Events seen by the gate controller in one reference cycle.
    typedef struct packed {
        logic tick;      // last cycle of the gate window
        logic ack_edge;  // synchronized acknowledge toggled
    } gate_evt_t;

    // Place an edge count (already zero-extended) on the 16.16 grid,
    // saturating when the shift would push bits off the top.
    function automatic logic [RES_W-1:0] scale_count(
        input logic [RES_W-1:0] cnt,
        input int unsigned      shift
    );
        logic [RES_W-1:0] top;
        top = (shift == 0) ? '0 : (cnt >> (RES_W - shift));
        if (top != '0)
            return '1;
        return cnt << shift;
    endfunction

endpackage

// File: rtl/cfm_sync.sv
module cfm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) chain[0] <= d;

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) chain[s] <= chain[s-1];
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfm_gate_timer.sv
module cfm_gate_timer
    import cfm_pkg::*;
#(
    parameter int GATE_LOG2 = 16
) (
    input  logic ref_clk,
    input  logic ref_rst,
    input  logic ack_s,     // acknowledge toggle, already synchronized
    output logic req_tog,   // snapshot request toggle to measured domain
    output logic load       // one-cycle pulse: snapshot may be taken
);
    logic [GATE_LOG2-1:0] gate_cnt;
    logic                 ack_prev;
    gate_state_e          state;
    gate_evt_t            evt;

    assign evt.tick     = &gate_cnt;
    assign evt.ack_edge = ack_s ^ ack_prev;
    assign load         = (state == GT_PENDING) && evt.ack_edge;

    always_ff @(posedge ref_clk) begin
        if (ref_rst) begin
            gate_cnt <= '0;
            req_tog  <= 1'b0;
            ack_prev <= ack_s;
            state    <= GT_ARMED;
        end else begin
            gate_cnt <= gate_cnt + 1'b1;
            ack_prev <= ack_s;
            unique case (state)
                GT_ARMED: begin
                    if (evt.tick) begin
                        req_tog <= ~req_tog;
                        state   <= GT_PENDING;
                    end
                end
                GT_PENDING: begin
                    if (evt.ack_edge)
                        state <= GT_ARMED;
                end
                default: state <= GT_ARMED;
            endcase
        end
    end
endmodule

// File: rtl/cfm_edge_counter.sv
module cfm_edge_counter #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             meas_clk,
    input  logic             rst_async,  // reference reset, raw
    input  logic             req_async,  // request toggle, raw
    output logic [CNT_W-1:0] snap,
    output logic             ack_tog,
    output logic [CNT_W-1:0] live_cnt,
    output logic             capture,
    output logic             rst_m
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic req_s;
    logic req_prev;

    cfm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
        .clk (meas_clk),
        .d   (rst_async),
        .q   (rst_m)
    );

    cfm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk (meas_clk),
        .d   (req_async),
        .q   (req_s)
    );

    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
        return (c == CNT_MAX) ? c : c + 1'b1;
    endfunction

    assign capture = (req_s ^ req_prev) & ~rst_m;

    always_ff @(posedge meas_clk) begin
        if (rst_m) begin
            live_cnt <= '0;
            snap     <= '0;
            ack_tog  <= 1'b0;
            req_prev <= req_s;
        end else begin
            req_prev <= req_s;
            if (capture) begin
                // The capturing edge closes the old window.
                snap     <= bump(live_cnt);
                live_cnt <= '0;
                ack_tog  <= ~ack_tog;
            end else begin
                live_cnt <= bump(live_cnt);
            end
        end
    end
endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter
    import cfm_pkg::*;
#(
    parameter int GATE_LOG2   = 16,  // window = 2**GATE_LOG2 reference cycles, <= 16
    parameter int CNT_W       = 32,  // edge counter width, <= 32
    parameter int SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             ref_rst,
    input  logic             meas_clk,
    output logic [RES_W-1:0] freq_q
);
    localparam int unsigned SHIFT = FRAC_W - GATE_LOG2;

    logic             req_tog;
    logic             load;
    logic             ack_tog;
    logic             ack_s;
    logic             capture;
    logic             rst_m;
    logic [CNT_W-1:0] snap;
    logic [CNT_W-1:0] live_cnt;
    logic [RES_W-1:0] snap_ext;

    cfm_gate_timer #(.GATE_LOG2(GATE_LOG2)) u_gate (
        .ref_clk (ref_clk),
        .ref_rst (ref_rst),
        .ack_s   (ack_s),
        .req_tog (req_tog),
        .load    (load)
    );

    cfm_edge_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_count (
        .meas_clk  (meas_clk),
        .rst_async (ref_rst),
        .req_async (req_tog),
        .snap      (snap),
        .ack_tog   (ack_tog),
        .live_cnt  (live_cnt),
        .capture   (capture),
        .rst_m     (rst_m)
    );

    cfm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (ref_clk),
        .d   (ack_tog),
        .q   (ack_s)
    );

    // Snapshot is held since before the acknowledge left the measured domain.
    assign snap_ext = RES_W'(snap);

    always_ff @(posedge ref_clk) begin
        if (ref_rst)
            freq_q <= '0;
        else if (load)
            freq_q <= scale_count(snap_ext, SHIFT);
    end
endmodule

// File: rtl/cfm_checker.sv
module cfm_checker #(
    parameter int GATE_LOG2 = 16,
    parameter int CNT_W     = 32
) (
    input logic             ref_clk,
    input logic             ref_rst,
    input logic [31:0]      freq_q,
    input logic             req_tog,
    input logic             load,
    input logic             meas_clk,
    input logic             rst_m,
    input logic [CNT_W-1:0] live_cnt,
    input logic             capture,
    input logic [CNT_W-1:0] snap
);
    localparam int          SHIFT = 16 - GATE_LOG2;
    localparam logic [31:0] FMASK = (32'd1 << SHIFT) - 32'd1;
    localparam logic [CNT_W-1:0] CMAX = '1;

    // Independent window phase counter.
    logic [GATE_LOG2-1:0] phase;
    always_ff @(posedge ref_clk) begin
        if (ref_rst) phase <= '0;
        else         phase <= phase + 1'b1;
    end

    assert_grid_R1: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (freq_q & FMASK) == 32'd0);

    assert_window_R2: assert property (@(posedge ref_clk) disable iff (ref_rst)
        !$stable(req_tog) |-> phase == '0);

    assert_reset_zero_R3: assert property (@(posedge ref_clk)
        ref_rst |=> freq_q == 32'd0);

    assert_hold_R4: assert property (@(posedge ref_clk) disable iff (ref_rst)
        !$stable(freq_q) |-> ($past(load) || $past(ref_rst)));

    assert_no_wrap_R5: assert property (@(posedge meas_clk) disable iff (rst_m)
        (live_cnt == CMAX && !capture) |=> live_cnt == CMAX);

    assert_snap_held_R6: assert property (@(posedge meas_clk) disable iff (rst_m)
        !capture |=> $stable(snap));
endmodule

bind clk_freq_meter cfm_checker #(
    .GATE_LOG2 (GATE_LOG2),
    .CNT_W     (CNT_W)
) u_cfm_checker (
    .ref_clk  (ref_clk),
    .ref_rst  (ref_rst),
    .freq_q   (freq_q),
    .req_tog  (req_tog),
    .load     (load),
    .meas_clk (meas_clk),
    .rst_m    (rst_m),
    .live_cnt (live_cnt),
    .capture  (capture),
    .snap     (snap)
);

// File: tb/test_clk_freq_meter.sv
`timescale 1ns/10ps
module test_clk_freq_meter;
    localparam real REF_PERIOD = 10.0;
    localparam int  GLOG       = 6;
    localparam int  GATE       = 1 << GLOG;
    localparam int  CW         = 9;
    localparam int  SHIFT      = 16 - GLOG;
    localparam int  CMAX       = (1 << CW) - 1;

    logic        ref_clk  = 1'b0;
    logic        meas_clk = 1'b0;
    logic        ref_rst  = 1'b1;
    logic [31:0] freq_q;
    real         meas_half = 5.0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    clk_freq_meter #(.GATE_LOG2(GLOG), .CNT_W(CW), .SYNC_STAGES(2)) i_clk_freq_meter (
        .ref_clk  (ref_clk),
        .ref_rst  (ref_rst),
        .meas_clk (meas_clk),
        .freq_q   (freq_q)
    );

    always #(REF_PERIOD / 2.0) ref_clk = ~ref_clk;
    always #(meas_half) meas_clk = ~meas_clk;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic bit near(input logic [31:0] v, input int exp_cnt);
        int got;
        got = int'(v >> SHIFT);
        return ((v & ((32'd1 << SHIFT) - 1)) == 0) &&
               (got >= exp_cnt - 1) && (got <= exp_cnt + 1);
    endfunction

    // Expected edge count for a measured period, saturated at counter max.
    function automatic int expect_cnt(input real per);
        int n;
        n = int'((real'(GATE) * REF_PERIOD) / per);
        return (n > CMAX) ? CMAX : n;
    endfunction

    task automatic run_freq(input real per, input string req);
        int          e;
        int          changes;
        bit          all_ok;
        logic [31:0] prev;
        meas_half = per / 2.0;
        e = expect_cnt(per);
        repeat (4 * GATE) @(posedge ref_clk);
        // R1 / R2 / R5: value at several points
        for (int k = 0; k < 4; k++) begin
            @(negedge ref_clk);
            check(near(freq_q, e), req, freq_q, 32'(e) << SHIFT);
            repeat (GATE / 4) @(posedge ref_clk);
        end
        // R4 and R6: within one window at most one change, every sample sane
        @(negedge ref_clk);
        prev    = freq_q;
        changes = 0;
        all_ok  = 1'b1;
        for (int k = 0; k < GATE - 4; k++) begin
            @(negedge ref_clk);
            if (freq_q != prev) changes++;
            if (!near(freq_q, e)) all_ok = 1'b0;
            prev = freq_q;
        end
        check(changes <= 1, "R4", 32'(changes), 32'd1);
        check(all_ok, "R6", freq_q, 32'(e) << SHIFT);
    endtask

    initial begin
        #(200000.0 * REF_PERIOD);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20) @(posedge ref_clk);
        @(negedge ref_clk);
        check(freq_q == 32'd0, "R3 in reset", freq_q, 32'd0);
        ref_rst = 1'b0;
        repeat (30) @(posedge ref_clk);
        @(negedge ref_clk);
        check(freq_q == 32'd0, "R3 before first window", freq_q, 32'd0);

        run_freq(10.0,  "R1 R2 equal clocks");  // 64 -> 0x0001_0000
        run_freq(20.0,  "R1 half rate");        // 32
        run_freq(5.0,   "R1 double rate");      // 128
        run_freq(40.0,  "R1 quarter rate");     // 16
        run_freq(4.0,   "R1 2.5x rate");        // 160
        run_freq(80.0,  "R1 eighth rate");      // 8
        run_freq(2.5,   "R1 4x rate");          // 256
        run_freq(128.0, "R1 slow clock");       // 5
        run_freq(1.0,   "R5 saturation");       // 640 -> 511

        // R3: reset in mid-operation clears and holds zero
        meas_half = 5.0;
        repeat (4 * GATE) @(posedge ref_clk);
        ref_rst = 1'b1;
        repeat (10) @(posedge ref_clk);
        @(negedge ref_clk);
        check(freq_q == 32'd0, "R3 mid reset", freq_q, 32'd0);
        ref_rst = 1'b0;
        repeat (30) @(posedge ref_clk);
        @(negedge ref_clk);
        check(freq_q == 32'd0, "R3 after mid reset", freq_q, 32'd0);
        run_freq(10.0, "R1 after reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule